// File: doc/BRIEF.md
# Pop-Suppressing Power Sequencer

This block walks the analog sections of an audio converter through their power transitions in an order that keeps clicks out of the speakers and headphones. A single power-on request brings up the mid-rail and reference, waits a programmable time for the reference capacitor to charge, enables the converters, enables the output drivers, and only then releases the converter mute. A power-off request always starts by muting. It then follows one of two orderings, chosen by a mode bit captured with the request. The quiet ordering drops the output drivers before the reference. The fast ordering drops the reference while the drivers are still on, so the mid-rail discharges quickly, and clears the drivers one clock later.

A request in the opposite direction to a sequence already in progress is remembered. It starts only after that sequence reaches its resting state (standby or active). The current state code and a busy flag are reported for a supervising controller.

Top module: `pop_free_pwr_seq`

## Requirements
- R1: After reset, and after any clock edge that sees `rst_n` low, the block is in standby: `state_o` = 0, all three enables are 0, `dac_mute` = 1 and `busy` = 0.
- R2: State codes and their outputs (ref_en, dac_en, drv_en, dac_mute) are: 0 standby (0,0,0,1), 1 reference charging (1,0,0,1), 2 converters on (1,1,0,1), 3 drivers on (1,1,1,1), 4 active (1,1,1,0), 5 muting (1,1,1,1), 6 drivers off (1,1,0,1), 7 reference off (0,0,1,1). Power-on runs 1, 2, 3, 4, and states 2 and 3 each last one clock.
- R3: State 1 lasts `settle_cycles`+1 clocks. The count is captured on entry, so a value of 0 gives one clock, and a later change of the input has no effect on the wait in progress.
- R4: Unmuting is the final power-on step: the block enters state 4 with `dac_mute` = 0, and `dac_mute` is 0 in no other state.
- R5: Quiet power-off (`fast_mode` = 0) runs 5, 6, 0 with one clock in each state, so the drivers go off before the reference.
- R6: Fast power-off (`fast_mode` = 1) runs 5, 7, 0 with one clock in each state. The reference and converters go off while the drivers stay on, and the drivers go off one clock later.
- R7: `fast_mode` is sampled when the power-off request is taken (or when it is remembered as pending). Later changes of `fast_mode` do not alter that shutdown.
- R8: A power-on request seen in states 5–7, or a power-off request seen in states 1–3, is held. It starts after the resting state (0 or 4) has been shown for exactly one clock.
- R9: A power-on request in states 1–4 and a power-off request in states 0 or 5–7 have no effect.
- R10: When both requests are seen together, power-on wins in state 0 and power-off wins in state 4.
- R11: `busy` is 1 in states 1–3 and 5–7 and 0 in states 0 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwr_up_req | input | 1 | Power-on request, sampled each clock |
| pwr_dn_req | input | 1 | Power-off request, sampled each clock |
| fast_mode | input | 1 | Shutdown ordering for a power-off request: 1 fast, 0 quiet |
| settle_cycles | input | 16 | Extra clocks to hold the reference-charging state |
| ref_en | output | 1 | Mid-rail and reference enable |
| dac_en | output | 1 | Converter enable |
| drv_en | output | 1 | Output driver enable |
| dac_mute | output | 1 | Converter digital mute |
| state_o | output | 3 | Current state code (see R2) |
| busy | output | 1 | A sequence is in progress |

## Verification
The checker treats the request lines and `fast_mode` as synchronous, known levels sampled at the rising edge. Its properties must hold for any pattern of requests, including requests held for many clocks or arriving in illegal states. The ordering properties involve only the enables and the mute, so they do not depend on the value of `settle_cycles`. The bench changes every input on the falling edge, so each request is a clean level at the next rising edge. It deliberately asserts requests in states where they should be ignored, deferred or in conflict, and it changes `settle_cycles` and `fast_mode` while a sequence is running.

// File: rtl/pop_seq_pkg.sv
// Shared types for the power sequencer: state codes and the decoded output set.
// Assumes the state codes are visible to software, so their values are fixed.
package pop_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_STANDBY = 3'd0,
        SEQ_REF_UP  = 3'd1,
        SEQ_DAC_UP  = 3'd2,
        SEQ_DRV_UP  = 3'd3,
        SEQ_ACTIVE  = 3'd4,
        SEQ_MUTE    = 3'd5,
        SEQ_DRV_OFF = 3'd6,
        SEQ_REF_OFF = 3'd7
    } seq_state_t;

    typedef struct packed {
        logic ref_en;
        logic dac_en;
        logic drv_en;
        logic mute;
        logic busy;
    } seq_out_t;

    // Output set that belongs to each state.
    function automatic seq_out_t seq_decode(input seq_state_t s);
        seq_out_t o;
        case (s)
            SEQ_STANDBY: o = '{ref_en:1'b0, dac_en:1'b0, drv_en:1'b0, mute:1'b1, busy:1'b0};
            SEQ_REF_UP:  o = '{ref_en:1'b1, dac_en:1'b0, drv_en:1'b0, mute:1'b1, busy:1'b1};
            SEQ_DAC_UP:  o = '{ref_en:1'b1, dac_en:1'b1, drv_en:1'b0, mute:1'b1, busy:1'b1};
            SEQ_DRV_UP:  o = '{ref_en:1'b1, dac_en:1'b1, drv_en:1'b1, mute:1'b1, busy:1'b1};
            SEQ_ACTIVE:  o = '{ref_en:1'b1, dac_en:1'b1, drv_en:1'b1, mute:1'b0, busy:1'b0};
            SEQ_MUTE:    o = '{ref_en:1'b1, dac_en:1'b1, drv_en:1'b1, mute:1'b1, busy:1'b1};
            SEQ_DRV_OFF: o = '{ref_en:1'b1, dac_en:1'b1, drv_en:1'b0, mute:1'b1, busy:1'b1};
            SEQ_REF_OFF: o = '{ref_en:1'b0, dac_en:1'b0, drv_en:1'b1, mute:1'b1, busy:1'b1};
            default:     o = '{ref_en:1'b0, dac_en:1'b0, drv_en:1'b0, mute:1'b1, busy:1'b0};
        endcase
        return o;
    endfunction

    // True for the states of the power-on ramp.
    function automatic logic seq_is_ramp_up(input seq_state_t s);
        return (s == SEQ_REF_UP) || (s == SEQ_DAC_UP) || (s == SEQ_DRV_UP);
    endfunction

    // True for the states of either power-off ramp.
    function automatic logic seq_is_ramp_down(input seq_state_t s);
        return (s == SEQ_MUTE) || (s == SEQ_DRV_OFF) || (s == SEQ_REF_OFF);
    endfunction

endpackage

// File: rtl/pop_seq_settle.sv
// Reference settle timer: a down-counter loaded on entry to the charging
// state and stepped while in it. Assumes load and step are never both
// needed in the same clock (the FSM loads only from standby).
module pop_seq_settle #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    // Hold the remaining wait; reload on entry, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (load)                     cnt_q <= load_val;
        else if (step && (cnt_q != '0))    cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/pop_seq_req.sv
// Request arbiter: decides when a power-on or power-off starts, remembers
// requests that arrive in the middle of the opposite ramp, and captures the
// shutdown mode. Assumes the request inputs are synchronous levels.
module pop_seq_req
    import pop_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_t state,
    input  logic       up_req,
    input  logic       dn_req,
    input  logic       fast_mode,
    output logic       go_up,
    output logic       go_dn,
    output logic       go_fast
);
    logic pend_up_q;
    logic pend_dn_q;
    logic pend_fast_q;

    // Start conditions: a live or remembered request in a resting state.
    always_comb begin
        go_up   = (state == SEQ_STANDBY) && (up_req || pend_up_q);
        go_dn   = (state == SEQ_ACTIVE)  && (dn_req || pend_dn_q);
        go_fast = dn_req ? fast_mode : pend_fast_q;
    end

    // Remember a power-on request seen during a power-off ramp.
    always_ff @(posedge clk) begin
        if (!rst_n)                               pend_up_q <= 1'b0;
        else if (go_up)                           pend_up_q <= 1'b0;
        else if (up_req && seq_is_ramp_down(state)) pend_up_q <= 1'b1;
    end

    // Remember a power-off request (and its mode) seen during power-on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_dn_q   <= 1'b0;
            pend_fast_q <= 1'b0;
        end else if (go_dn) begin
            pend_dn_q   <= 1'b0;
        end else if (dn_req && seq_is_ramp_up(state)) begin
            pend_dn_q   <= 1'b1;
            pend_fast_q <= fast_mode;
        end
    end
endmodule

// File: rtl/pop_seq_fsm.sv
// Sequencing state machine. Steps through the power-on ramp and the quiet
// or fast power-off ramp. Assumes go_up only arrives in standby and go_dn
// only in active (guaranteed by the arbiter).
module pop_seq_fsm
    import pop_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_up,
    input  logic       go_dn,
    input  logic       go_fast,
    input  logic       settle_done,
    output seq_state_t state_q,
    output seq_state_t state_d,
    output logic       settle_load,
    output logic       settle_step
);
    logic fast_q;

    // Next-state selection.
    always_comb begin
        state_d = state_q;
        case (state_q)
            SEQ_STANDBY: if (go_up)       state_d = SEQ_REF_UP;
            SEQ_REF_UP:  if (settle_done) state_d = SEQ_DAC_UP;
            SEQ_DAC_UP:                   state_d = SEQ_DRV_UP;
            SEQ_DRV_UP:                   state_d = SEQ_ACTIVE;
            SEQ_ACTIVE:  if (go_dn)       state_d = SEQ_MUTE;
            SEQ_MUTE:                     state_d = fast_q ? SEQ_REF_OFF : SEQ_DRV_OFF;
            SEQ_DRV_OFF:                  state_d = SEQ_STANDBY;
            SEQ_REF_OFF:                  state_d = SEQ_STANDBY;
            default:                      state_d = SEQ_STANDBY;
        endcase
    end

    // Settle timer control: load on the way in, step while charging.
    always_comb begin
        settle_load = (state_q == SEQ_STANDBY) && go_up;
        settle_step = (state_q == SEQ_REF_UP);
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEQ_STANDBY;
        else        state_q <= state_d;
    end

    // Shutdown mode captured when the power-off starts.
    always_ff @(posedge clk) begin
        if (!rst_n)     fast_q <= 1'b0;
        else if (go_dn) fast_q <= go_fast;
    end
endmodule

// File: rtl/pop_seq_drv.sv
// Output stage: registers the decoded outputs of the next state, so every
// enable and the mute come straight from a flop, aligned with the state.
module pop_seq_drv
    import pop_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_t state_d,
    output seq_out_t   outs_q
);
    // Register the decoded outputs; reset forces the standby set.
    always_ff @(posedge clk) begin
        if (!rst_n) outs_q <= seq_decode(SEQ_STANDBY);
        else        outs_q <= seq_decode(state_d);
    end
endmodule

// File: rtl/pop_free_pwr_seq.sv
// Top of the pop-suppressing power sequencer. Connects the arbiter, the
// state machine, the settle timer and the output stage. Assumes a single
// clock domain and synchronous request inputs.
module pop_free_pwr_seq
    import pop_seq_pkg::*;
#(
    parameter int SETTLE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pwr_up_req,
    input  logic                pwr_dn_req,
    input  logic                fast_mode,
    input  logic [SETTLE_W-1:0] settle_cycles,
    output logic                ref_en,
    output logic                dac_en,
    output logic                drv_en,
    output logic                dac_mute,
    output logic [2:0]          state_o,
    output logic                busy
);
    seq_state_t state_q;
    seq_state_t state_d;
    seq_out_t   outs_q;
    logic       go_up;
    logic       go_dn;
    logic       go_fast;
    logic       settle_load;
    logic       settle_step;
    logic       settle_done;

    pop_seq_req u_req (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state_q),
        .up_req    (pwr_up_req),
        .dn_req    (pwr_dn_req),
        .fast_mode (fast_mode),
        .go_up     (go_up),
        .go_dn     (go_dn),
        .go_fast   (go_fast)
    );

    pop_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_up       (go_up),
        .go_dn       (go_dn),
        .go_fast     (go_fast),
        .settle_done (settle_done),
        .state_q     (state_q),
        .state_d     (state_d),
        .settle_load (settle_load),
        .settle_step (settle_step)
    );

    pop_seq_settle #(.CNT_W(SETTLE_W)) u_settle (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (settle_load),
        .load_val (settle_cycles),
        .step     (settle_step),
        .done     (settle_done)
    );

    pop_seq_drv u_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_d (state_d),
        .outs_q  (outs_q)
    );

    // Drive the ports from the state register and the output stage.
    always_comb begin
        ref_en   = outs_q.ref_en;
        dac_en   = outs_q.dac_en;
        drv_en   = outs_q.drv_en;
        dac_mute = outs_q.mute;
        busy     = outs_q.busy;
        state_o  = state_q;
    end
endmodule

// File: rtl/pop_free_pwr_seq_chk.sv
// Ordering checker for the power sequencer, bound to the top module.
// Assumes synchronous, known inputs; holds for any request pattern.
module pop_free_pwr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_en,
    input logic       dac_en,
    input logic       drv_en,
    input logic       dac_mute,
    input logic [2:0] state_o,
    input logic       busy
);
    assert_standby_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0) |-> (!ref_en && !dac_en && !drv_en && dac_mute && !busy));

    assert_dac_needs_ref_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dac_en |-> ref_en);

    assert_ref_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_en) |-> (!dac_en && !drv_en && dac_mute));

    assert_unmute_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_mute |-> (ref_en && dac_en && drv_en && state_o == 3'd4));

    assert_mute_before_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($fell(drv_en) || $fell(ref_en))) |-> (dac_mute && $past(dac_mute)));

    assert_quiet_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd6) |-> (ref_en && !drv_en));

    assert_fast_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd7) |=> (state_o == 3'd0 && !drv_en));

    assert_rest_not_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4) |-> !busy);
endmodule

bind pop_free_pwr_seq pop_free_pwr_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_en   (ref_en),
    .dac_en   (dac_en),
    .drv_en   (drv_en),
    .dac_mute (dac_mute),
    .state_o  (state_o),
    .busy     (busy)
);

// File: tb/pop_free_pwr_seq_test.sv
module pop_free_pwr_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_up_req = 1'b0;
    logic        pwr_dn_req = 1'b0;
    logic        fast_mode = 1'b0;
    logic [15:0] settle_cycles = '0;
    logic        ref_en, dac_en, drv_en, dac_mute, busy;
    logic [2:0]  state_o;
    int          checks = 0;
    int          fails = 0;
    logic        done = 1'b0;

    always #5 clk = ~clk;

    pop_free_pwr_seq uut (
        .clk(clk), .rst_n(rst_n), .pwr_up_req(pwr_up_req), .pwr_dn_req(pwr_dn_req),
        .fast_mode(fast_mode), .settle_cycles(settle_cycles), .ref_en(ref_en),
        .dac_en(dac_en), .drv_en(drv_en), .dac_mute(dac_mute), .state_o(state_o),
        .busy(busy)
    );

    // {settle_cycles, fast_mode} walked by the main loop
    localparam logic [16:0] VEC [6] = '{
        {16'd0, 1'b0}, {16'd1, 1'b1}, {16'd5, 1'b0},
        {16'd3, 1'b1}, {16'd12, 1'b0}, {16'd0, 1'b1}
    };

    // Expected {state, ref, dac, drv, mute, busy} from the R2/R11 table
    function automatic logic [7:0] exp_vec(input logic [2:0] s);
        case (s)
            3'd0: return {s, 5'b00010};
            3'd1: return {s, 5'b10011};
            3'd2: return {s, 5'b11011};
            3'd3: return {s, 5'b11111};
            3'd4: return {s, 5'b11100};
            3'd5: return {s, 5'b11111};
            3'd6: return {s, 5'b11011};
            default: return {s, 5'b00111};
        endcase
    endfunction

    task automatic chk(input logic [2:0] e, input string tag);
        logic [7:0] act;
        act = {state_o, ref_en, dac_en, drv_en, dac_mute, busy};
        checks++;
        if (act !== exp_vec(e)) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, act, exp_vec(e));
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        chk(3'd0, "R1 reset state");
        tick();

        // R9: power-off in standby is ignored
        pwr_dn_req = 1'b1; tick(); pwr_dn_req = 1'b0;
        for (int i = 0; i < 3; i++) begin chk(3'd0, "R9 down in standby"); tick(); end

        // Table walk: R2 R3 R4 R5 R6 R11
        for (int v = 0; v < 6; v++) begin
            settle_cycles = VEC[v][16:1];
            fast_mode = VEC[v][0];
            pwr_up_req = 1'b1; tick(); pwr_up_req = 1'b0;
            for (int i = 0; i <= int'(VEC[v][16:1]); i++) begin chk(3'd1, "R3 settle"); tick(); end
            chk(3'd2, "R2 converters"); tick();
            chk(3'd3, "R2 drivers"); tick();
            chk(3'd4, "R4 unmuted active"); tick();
            pwr_dn_req = 1'b1; tick(); pwr_dn_req = 1'b0;
            chk(3'd5, "R5 mute first"); tick();
            if (VEC[v][0]) chk(3'd7, "R6 fast ref off");
            else           chk(3'd6, "R5 quiet drivers off");
            tick();
            chk(3'd0, "R11 back to standby"); tick();
        end

        // R10: both in standby, power-on wins; R9 up during ramp ignored
        settle_cycles = 16'd2;
        pwr_up_req = 1'b1; pwr_dn_req = 1'b1; tick();
        pwr_up_req = 1'b0; pwr_dn_req = 1'b0;
        chk(3'd1, "R10 up wins in standby"); tick();
        pwr_up_req = 1'b1;
        chk(3'd1, "R9 up during ramp"); tick();
        pwr_up_req = 1'b0;
        chk(3'd1, "R3 settle 2"); tick();
        chk(3'd2, "R9 ramp unchanged"); tick();
        chk(3'd3, "R2"); tick();
        chk(3'd4, "R4"); tick();
        pwr_up_req = 1'b1; pwr_dn_req = 1'b1; fast_mode = 1'b1; tick();
        pwr_up_req = 1'b0; pwr_dn_req = 1'b0;
        chk(3'd5, "R10 down wins in active"); tick();
        chk(3'd7, "R6"); tick();
        chk(3'd0, "R6 standby"); tick();
        chk(3'd0, "R9 no leftover up"); tick();

        // R8/R7: power-off pending during power-on, fast captured then input changed
        settle_cycles = 16'd3;
        pwr_up_req = 1'b1; tick(); pwr_up_req = 1'b0;
        pwr_dn_req = 1'b1; fast_mode = 1'b1;
        chk(3'd1, "R3"); tick();
        pwr_dn_req = 1'b0; fast_mode = 1'b0;
        for (int i = 0; i < 3; i++) begin chk(3'd1, "R8 pending keeps settle"); tick(); end
        chk(3'd2, "R8"); tick();
        chk(3'd3, "R8"); tick();
        chk(3'd4, "R8 active shown one cycle"); tick();
        chk(3'd5, "R8 pending down starts"); tick();
        chk(3'd7, "R7 pending mode kept"); tick();
        chk(3'd0, "R6"); tick();

        // R8/R7: power-on pending during quiet power-off; mode change mid-ramp
        settle_cycles = 16'd0;
        pwr_up_req = 1'b1; tick(); pwr_up_req = 1'b0;
        chk(3'd1, "R3 zero wait"); tick();
        chk(3'd2, "R3 zero wait"); tick();
        chk(3'd3, "R2"); tick();
        chk(3'd4, "R4"); tick();
        pwr_dn_req = 1'b1; fast_mode = 1'b0; tick(); pwr_dn_req = 1'b0;
        chk(3'd5, "R5"); pwr_up_req = 1'b1; fast_mode = 1'b1; tick(); pwr_up_req = 1'b0;
        chk(3'd6, "R7 quiet kept"); tick();
        chk(3'd0, "R8 standby shown one cycle"); tick();
        chk(3'd1, "R8 pending up starts"); tick();
        chk(3'd2, "R8"); tick();
        chk(3'd3, "R8"); tick();
        chk(3'd4, "R8"); tick();
        pwr_dn_req = 1'b1; fast_mode = 1'b0; tick(); pwr_dn_req = 1'b0;
        chk(3'd5, "R5"); tick();
        chk(3'd6, "R5"); tick();
        chk(3'd0, "R5"); tick();

        // R3: settle value captured at entry; then R1 reset mid-ramp
        settle_cycles = 16'd6;
        pwr_up_req = 1'b1; tick(); pwr_up_req = 1'b0;
        settle_cycles = 16'd0;
        for (int i = 0; i < 7; i++) begin chk(3'd1, "R3 captured count"); tick(); end
        chk(3'd2, "R3 captured count"); tick();
        chk(3'd3, "R2"); rst_n = 1'b0; tick();
        chk(3'd0, "R1 sync reset"); rst_n = 1'b1; tick();
        chk(3'd0, "R1 stays standby"); tick();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule